// File: doc/BRIEF.md
# Service-Class Priority Arbiter

This block settles contention for one output port of a bufferless on-chip router. In every cycle up to four input ports may each present one request. A request carries a service class, the number of hops its flit has travelled, and an identifier. The block maps each request to one of four priority levels and files it into that level's queue. At the next clock edge it reports a single winner. Nothing persists across cycles: each clock edge discards the previous contents of all queues and loads them with the requests present at that edge.

Control flits always take precedence over the other classes. Read/write traffic takes precedence over bulk transfers. A read/write or bulk flit that has travelled at least `MAX_HOP` hops is raised to a dedicated escalated level, so that a flit cannot be deflected without bound. Within the escalated level the flit that has travelled furthest wins. Within every other level the flit that entered the queue first wins. Requests enter the queues in polling order, starting from a rotating input port, so that no input port is favoured permanently.

The same module serves both allocation stages of the router. An instance built with `STAGE2 = 1` never serves the bulk level.

Top module: `prio_class_arbiter`

## Requirements
- R1: After a synchronous reset every queue is empty, `win_valid` is 0 and the polling start port is input 0. A request presented while reset is high never produces a winner.
- R2: The 2-bit `req_cls` field uses these codes: 0 is a control (setup) flit at level 0, 1 is a read/write flit at level 2, 2 is a bulk flit at level 3. Code 3 is reserved, and a request carrying it is ignored.
- R3: A read/write or bulk request whose `req_hop` is greater than or equal to `MAX_HOP` (default 16) is placed at level 1. A control request stays at level 0 whatever its hop count.
- R4: The winner is taken from the lowest-numbered non-empty level. Level 0 is the highest priority.
- R5: At level 1 the entry with the largest hop count wins. When hop counts are equal, the entry that is earlier in the queue wins.
- R6: At levels 0, 2 and 3 the entry that entered the queue first wins.
- R7: Requests enter the queues in port order, starting at the polling start port and wrapping modulo `N_IN`. The start port advances by one, modulo `N_IN`, in every cycle that has at least one non-ignored request, and otherwise holds its value.
- R8: The requests sampled at one clock edge determine `win_valid` and `win_id` until the next edge. They do not compete at any later edge. An edge with no non-ignored request gives `win_valid` = 0.
- R9: With `STAGE2 = 1` level 3 is never served. If only level-3 requests are present, `win_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | N_IN | One request-present bit per input port |
| req_cls | input | N_IN x 2 | Service class code per port |
| req_hop | input | N_IN x HOP_W | Hops travelled per port |
| req_id | input | N_IN x ID_W | Identifier per port |
| win_valid | output | 1 | A winner exists for the requests sampled at the last edge |
| win_id | output | ID_W | Identifier of that winner |

## Verification
The assertions assume that the requester holds `req_*` steady across each rising edge, and that `MAX_HOP` can be reached within `HOP_W` bits. The stimulus changes the inputs only on falling edges. It keeps every hop value inside 5 bits, and gives every request an identifier that is unique within its cycle. With unique identifiers, `win_id` alone shows which port won. The vectors visit every polling start port, so each winner depends on the rotation as well as on class and hop count.

// File: rtl/pca_pkg.sv
package pca_pkg;

    localparam int NUM_LVL = 4;

    typedef enum logic [1:0] {
        CLS_SETUP = 2'd0,
        CLS_RDWR  = 2'd1,
        CLS_BULK  = 2'd2,
        CLS_RSVD  = 2'd3
    } svc_cls_e;

    typedef enum logic [1:0] {
        LVL_CIRCUIT = 2'd0,
        LVL_AGED    = 2'd1,
        LVL_ACCESS  = 2'd2,
        LVL_BULK    = 2'd3
    } prio_lvl_e;

    // priority level of one request; aged means the hop limit is reached
    function automatic logic [1:0] level_of(input svc_cls_e cls, input logic aged);
        case (cls)
            CLS_SETUP: return LVL_CIRCUIT;
            CLS_RDWR:  return aged ? LVL_AGED : LVL_ACCESS;
            CLS_BULK:  return aged ? LVL_AGED : LVL_BULK;
            default:   return LVL_BULK;
        endcase
    endfunction

    // number of levels a given stage scans
    function automatic int scan_levels(input bit second_stage);
        return second_stage ? NUM_LVL - 1 : NUM_LVL;
    endfunction

endpackage

// File: rtl/pca_classify.sv
module pca_classify
    import pca_pkg::*;
#(
    parameter int N_IN    = 4,
    parameter int HOP_W   = 5,
    parameter int MAX_HOP = 16
) (
    input  logic [N_IN-1:0]            req_valid,
    input  logic [N_IN-1:0][1:0]       req_cls,
    input  logic [N_IN-1:0][HOP_W-1:0] req_hop,
    output logic [N_IN-1:0]            legal,
    output logic [N_IN-1:0][1:0]       lvl
);

    for (genvar p = 0; p < N_IN; p++) begin : g_port
        svc_cls_e cls;
        logic     aged;
        assign cls      = svc_cls_e'(req_cls[p]);
        assign aged     = (32'(req_hop[p]) >= MAX_HOP);
        assign legal[p] = req_valid[p] && (cls != CLS_RSVD);
        assign lvl[p]   = level_of(cls, aged);
    end

endmodule

// File: rtl/pca_queue_fill.sv
module pca_queue_fill
    import pca_pkg::*;
#(
    parameter  int N_IN  = 4,
    parameter  int HOP_W = 5,
    parameter  int ID_W  = 6,
    localparam int CNT_W = $clog2(N_IN + 1),
    localparam int PTR_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic [N_IN-1:0]                         legal,
    input  logic [N_IN-1:0][1:0]                    lvl,
    input  logic [N_IN-1:0][HOP_W-1:0]              req_hop,
    input  logic [N_IN-1:0][ID_W-1:0]               req_id,
    output logic [NUM_LVL-1:0][CNT_W-1:0]           q_cnt,
    output logic [NUM_LVL-1:0][N_IN-1:0][HOP_W-1:0] q_hop,
    output logic [NUM_LVL-1:0][N_IN-1:0][ID_W-1:0]  q_id
);

    typedef struct packed {
        logic [ID_W-1:0]  id;
        logic [HOP_W-1:0] hop;
    } slot_t;

    slot_t [NUM_LVL-1:0][N_IN-1:0] q_r, q_n;
    logic  [NUM_LVL-1:0][CNT_W-1:0] cnt_r, cnt_n;
    logic  [PTR_W-1:0]              ptr_r, ptr_n;

    // polling-order fill of all level queues from scratch
    always_comb begin
        int p;
        int l;
        int s;
        p     = 0;
        l     = 0;
        s     = 0;
        q_n   = '0;
        cnt_n = '0;
        for (int k = 0; k < N_IN; k++) begin
            p = (int'(ptr_r) + k) % N_IN;
            if (legal[p]) begin
                l = int'(lvl[p]);
                s = int'(cnt_n[l]);
                q_n[l][s].id  = req_id[p];
                q_n[l][s].hop = req_hop[p];
                cnt_n[l]      = cnt_n[l] + CNT_W'(1);
            end
        end
    end

    always_comb begin
        if (|legal) begin
            ptr_n = (ptr_r == PTR_W'(N_IN - 1)) ? '0 : ptr_r + PTR_W'(1);
        end else begin
            ptr_n = ptr_r;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r   <= '0;
            cnt_r <= '0;
            ptr_r <= '0;
        end else begin
            q_r   <= q_n;
            cnt_r <= cnt_n;
            ptr_r <= ptr_n;
        end
    end

    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        assign q_cnt[l] = cnt_r[l];
        for (genvar e = 0; e < N_IN; e++) begin : g_ent
            assign q_hop[l][e] = q_r[l][e].hop;
            assign q_id[l][e]  = q_r[l][e].id;
        end
    end

    logic [CNT_W+1:0] total_cnt;
    always_comb begin
        total_cnt = '0;
        for (int l = 0; l < NUM_LVL; l++) begin
            total_cnt = total_cnt + (CNT_W+2)'(cnt_r[l]);
        end
    end

    AST_QUEUE_TOTAL: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (int'(total_cnt) == $past($countones(legal)))); // R8

    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && (|legal)) |-> (int'(ptr_r) == ((int'($past(ptr_r)) + 1) % N_IN))); // R7

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && !(|legal)) |-> $stable(ptr_r)); // R7

endmodule

// File: rtl/pca_level_pick.sv
module pca_level_pick #(
    parameter  int N_IN     = 4,
    parameter  int HOP_W    = 5,
    parameter  int ID_W     = 6,
    parameter  bit PICK_MAX = 1'b0,
    localparam int CNT_W    = $clog2(N_IN + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [CNT_W-1:0]            q_cnt,
    input  logic [N_IN-1:0][HOP_W-1:0]  q_hop,
    input  logic [N_IN-1:0][ID_W-1:0]   q_id,
    output logic                        sel_valid,
    output logic [ID_W-1:0]             sel_id
);

    assign sel_valid = (q_cnt != '0);

    if (PICK_MAX) begin : g_max
        logic [HOP_W-1:0] best_hop;
        // strict compare keeps the earlier entry on equal hop counts
        always_comb begin
            best_hop = q_hop[0];
            sel_id   = q_id[0];
            for (int e = 1; e < N_IN; e++) begin
                if ((e < int'(q_cnt)) && (q_hop[e] > best_hop)) begin
                    best_hop = q_hop[e];
                    sel_id   = q_id[e];
                end
            end
        end
        for (genvar e = 0; e < N_IN; e++) begin : g_chk
            AST_AGED_MAX_HOP: assert property (@(posedge clk) disable iff (rst)
                (sel_valid && (e < int'(q_cnt))) |-> (best_hop >= q_hop[e])); // R5
        end
    end else begin : g_head
        assign sel_id = q_id[0];
        logic unused_hop;
        assign unused_hop = ^q_hop;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(q_cnt) <= N_IN); // R8

endmodule

// File: rtl/prio_class_arbiter.sv
module prio_class_arbiter
    import pca_pkg::*;
#(
    parameter int N_IN    = 4,
    parameter int HOP_W   = 5,
    parameter int ID_W    = 6,
    parameter int MAX_HOP = 16,
    parameter bit STAGE2  = 1'b0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [N_IN-1:0]            req_valid,
    input  logic [N_IN-1:0][1:0]       req_cls,
    input  logic [N_IN-1:0][HOP_W-1:0] req_hop,
    input  logic [N_IN-1:0][ID_W-1:0]  req_id,
    output logic                       win_valid,
    output logic [ID_W-1:0]            win_id
);

    localparam int CNT_W    = $clog2(N_IN + 1);
    localparam int SCAN_LVL = scan_levels(STAGE2);

    logic [N_IN-1:0]                         legal;
    logic [N_IN-1:0][1:0]                    lvl;
    logic [NUM_LVL-1:0][CNT_W-1:0]           q_cnt;
    logic [NUM_LVL-1:0][N_IN-1:0][HOP_W-1:0] q_hop;
    logic [NUM_LVL-1:0][N_IN-1:0][ID_W-1:0]  q_id;
    logic [SCAN_LVL-1:0]                     lvl_valid;
    logic [SCAN_LVL-1:0][ID_W-1:0]           lvl_id;
    logic [1:0]                              win_lvl;

    pca_classify #(
        .N_IN    (N_IN),
        .HOP_W   (HOP_W),
        .MAX_HOP (MAX_HOP)
    ) u_classify (
        .req_valid (req_valid),
        .req_cls   (req_cls),
        .req_hop   (req_hop),
        .legal     (legal),
        .lvl       (lvl)
    );

    pca_queue_fill #(
        .N_IN  (N_IN),
        .HOP_W (HOP_W),
        .ID_W  (ID_W)
    ) u_fill (
        .clk     (clk),
        .rst     (rst),
        .legal   (legal),
        .lvl     (lvl),
        .req_hop (req_hop),
        .req_id  (req_id),
        .q_cnt   (q_cnt),
        .q_hop   (q_hop),
        .q_id    (q_id)
    );

    for (genvar l = 0; l < SCAN_LVL; l++) begin : g_pick
        pca_level_pick #(
            .N_IN     (N_IN),
            .HOP_W    (HOP_W),
            .ID_W     (ID_W),
            .PICK_MAX (l == int'(LVL_AGED))
        ) u_pick (
            .clk       (clk),
            .rst       (rst),
            .q_cnt     (q_cnt[l]),
            .q_hop     (q_hop[l]),
            .q_id      (q_id[l]),
            .sel_valid (lvl_valid[l]),
            .sel_id    (lvl_id[l])
        );
    end

    // descending walk leaves the lowest non-empty level in place
    always_comb begin
        win_valid = 1'b0;
        win_id    = '0;
        win_lvl   = '0;
        for (int l = SCAN_LVL - 1; l >= 0; l--) begin
            if (lvl_valid[l]) begin
                win_valid = 1'b1;
                win_id    = lvl_id[l];
                win_lvl   = 2'(l);
            end
        end
    end

    logic any_setup;
    always_comb begin
        any_setup = 1'b0;
        for (int p = 0; p < N_IN; p++) begin
            if (legal[p] && (req_cls[p] == CLS_SETUP)) any_setup = 1'b1;
        end
    end

    AST_IDLE_NO_WIN: assert property (@(posedge clk) disable iff (rst)
        !$past(|legal) |-> !win_valid); // R8

    AST_SETUP_WINS: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && any_setup) |-> (win_valid && (win_lvl == LVL_CIRCUIT))); // R4

    AST_STAGE2_SKIPS_BULK: assert property (@(posedge clk) disable iff (rst)
        (STAGE2 && win_valid) |-> (win_lvl != LVL_BULK)); // R9

endmodule

// File: tb/test_prio_class_arbiter.sv
`timescale 1ns/1ps
module test_prio_class_arbiter;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0]      req_valid = '0;
    logic [3:0][1:0] req_cls   = '0;
    logic [3:0][4:0] req_hop   = '0;
    logic [3:0][5:0] req_id    = '0;
    logic            w1_valid, w2_valid;
    logic [5:0]      w1_id, w2_id;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    prio_class_arbiter #(.STAGE2(1'b0)) i_prio_class_arbiter (
        .clk (clk), .rst (rst), .req_valid (req_valid), .req_cls (req_cls),
        .req_hop (req_hop), .req_id (req_id), .win_valid (w1_valid), .win_id (w1_id));

    prio_class_arbiter #(.STAGE2(1'b1)) i_prio_class_arbiter_s2 (
        .clk (clk), .rst (rst), .req_valid (req_valid), .req_cls (req_cls),
        .req_hop (req_hop), .req_id (req_id), .win_valid (w2_valid), .win_id (w2_id));

    typedef struct packed {
        logic [3:0]      v;
        logic [3:0][1:0] c;
        logic [3:0][4:0] h;
        logic [3:0][5:0] id;
        logic            e1v;
        logic [5:0]      e1id;
        logic            e2v;
        logic [5:0]      e2id;
    } vec_t;

    function automatic logic [23:0] idset(input int b);
        return {6'(b + 3), 6'(b + 2), 6'(b + 1), 6'(b)};
    endfunction

    // class codes: 0 setup, 1 rd/wr, 2 bulk, 3 reserved; fields listed port3..port0
    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{4'b0000, 8'h00, 20'h0, idset(0), 1'b0, 6'd0, 1'b0, 6'd0},                          // R8 idle
        '{4'b1110, {2'd0,2'd2,2'd1,2'd0}, {5'd1,5'd2,5'd3,5'd0}, idset(4),
          1'b1, 6'd7, 1'b1, 6'd7},                                                             // R4 setup first
        '{4'b1101, {2'd2,2'd1,2'd0,2'd1}, {5'd0,5'd5,5'd0,5'd0}, idset(8),
          1'b1, 6'd10, 1'b1, 6'd10},                                                           // R7 start at port1
        '{4'b0110, {2'd0,2'd2,2'd2,2'd0}, {5'd0,5'd1,5'd4,5'd0}, idset(12),
          1'b1, 6'd14, 1'b0, 6'd0},                                                            // R6 R9 bulk only
        '{4'b1111, {2'd2,2'd1,2'd2,2'd1}, {5'd20,5'd15,5'd20,5'd16}, idset(16),
          1'b1, 6'd19, 1'b1, 6'd19},                                                           // R3 R5 tie by order
        '{4'b1111, {2'd1,2'd0,2'd1,2'd2}, {5'd2,5'd31,5'd31,5'd25}, idset(20),
          1'b1, 6'd22, 1'b1, 6'd22},                                                           // R3 setup stays top
        '{4'b1111, {2'd3,2'd2,2'd3,2'd3}, {5'd0,5'd0,5'd0,5'd30}, idset(24),
          1'b1, 6'd26, 1'b0, 6'd0},                                                            // R2 reserved ignored
        '{4'b1111, {2'd3,2'd3,2'd3,2'd3}, 20'h0, idset(28), 1'b0, 6'd0, 1'b0, 6'd0},          // R2 R7 no advance
        '{4'b1111, {2'd2,2'd2,2'd1,2'd1}, {5'd16,5'd16,5'd16,5'd16}, idset(32),
          1'b1, 6'd34, 1'b1, 6'd34},                                                           // R5 full tie
        '{4'b1111, {2'd1,2'd2,2'd1,2'd2}, {5'd1,5'd0,5'd9,5'd3}, idset(36),
          1'b1, 6'd39, 1'b1, 6'd39},                                                           // R4 R6 rdwr over bulk
        '{4'b1111, {2'd2,2'd1,2'd2,2'd1}, {5'd15,5'd18,5'd29,5'd17}, idset(40),
          1'b1, 6'd41, 1'b1, 6'd41},                                                           // R5 max hop
        '{4'b0011, {2'd0,2'd0,2'd1,2'd1}, {5'd0,5'd0,5'd15,5'd15}, idset(44),
          1'b1, 6'd45, 1'b1, 6'd45},                                                           // R3 just below limit
        '{4'b0000, 8'h00, 20'h0, idset(48), 1'b0, 6'd0, 1'b0, 6'd0},                          // R8 cleared
        '{4'b1001, {2'd2,2'd0,2'd0,2'd2}, {5'd7,5'd0,5'd0,5'd0}, idset(52),
          1'b1, 6'd55, 1'b0, 6'd0}                                                             // R7 R9 wrap order
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t vv);
        req_valid = vv.v;
        req_cls   = vv.c;
        req_hop   = vv.h;
        req_id    = vv.id;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset win_valid stage1", int'(w1_valid), 0);
        check("R1 reset win_valid stage2", int'(w2_valid), 0);
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            check($sformatf("R4 R5 R6 R7 row %0d stage1 valid", i), int'(w1_valid), int'(VECS[i].e1v));
            if (VECS[i].e1v)
                check($sformatf("R4 R5 R6 R7 row %0d stage1 id", i), int'(w1_id), int'(VECS[i].e1id));
            check($sformatf("R9 row %0d stage2 valid", i), int'(w2_valid), int'(VECS[i].e2v));
            if (VECS[i].e2v)
                check($sformatf("R9 row %0d stage2 id", i), int'(w2_id), int'(VECS[i].e2id));
        end
        // R1: requests during reset give no winner; start port returns to 0
        req_valid = 4'b1001;
        req_cls   = {2'd1, 2'd0, 2'd0, 2'd1};
        req_hop   = '0;
        req_id    = idset(56);
        rst       = 1'b1;
        @(negedge clk);
        check("R1 win_valid under reset stage1", int'(w1_valid), 0);
        check("R1 win_valid under reset stage2", int'(w2_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 R7 start port zero after reset", int'(w1_id), 56);
        check("R1 R7 start port zero after reset stage2", int'(w2_id), 56);
        req_valid = '0;
        @(negedge clk);
        check("R8 idle after reset test", int'(w1_valid), 0);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule